// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block recovers packets from the two data lines of a 1.5 Mbit/s USB link. The block is clocked at a nominal 20 MHz. Each line first passes through a two-flop synchroniser. The block then hunts for the sync field by watching for an idle-to-K transition. It accepts lock only when the next two mid-bit samples both read K. After lock it samples each bit near its centre and decodes NRZI. It drops the stuff bit that follows six ones and packs the data bits into bytes, least significant bit first.

A bit lasts 13 1/3 clocks, and the block tracks this with an open-loop pattern of 13- and 14-cycle periods. Inside each byte, the bits at index 1, 4 and 7 get one extra cycle. The extra cycle on bit 7 is skipped for every third byte, so three bytes take 320 cycles. Stuff bits take 13 cycles, with a fourteenth cycle on every third one.

Each completed byte leaves on a valid-only stream that has no ready input. The link cannot be paused, so the sink must take every beat. Beats are at least 13 cycles apart. A single-cycle end strobe reports the number of bytes delivered and whether the buffer limit was exceeded.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset, `rx_valid`, `pkt_done`, `pkt_overflow` and `pkt_bytes` are all 0.
- R2: Line states are {D+,D-}: J = 01 (idle), K = 10, SE0 = 00. Lock needs a J-to-K edge followed by K at two consecutive bit samples. A lone K pulse, or K followed by J, yields no beat and no `pkt_done`, and hunting resumes.
- R3: Equal consecutive line states decode to 1 and a change decodes to 0. Bytes are assembled LSB first. Each byte is presented for one cycle on `rx_data` with `rx_valid`, and `rx_index` counts 0, 1, 2, … within a packet.
- R4: The bit following six consecutive decoded ones is discarded. It updates only the reference line state, and the ones-run restarts at zero.
- R5: Data bit periods are 13 cycles, with 14 at byte-bit index 1, 4 and 7, except that index 7 of every third byte is 13. Stuff bit periods are 13 cycles, with 14 on every third stuff bit. Packets of up to 14 bytes sent at exactly 40/3 cycles per bit are recovered without error.
- R6: SE0 at a bit sample ends the packet. `pkt_done` pulses for one cycle, never together with `rx_valid`, and `pkt_bytes` equals the number of beats delivered. A partial byte is dropped.
- R7: At most `BUF_BYTES` (12) bytes are delivered per packet. If a further byte completes, no beat is sent for it and `pkt_overflow` is 1 with `pkt_done`.
- R8: After `pkt_done` the receiver hunts again, and the next packet is received normally, including after an overflowed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, nominally 20 MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| rx_valid | output | 1 | Byte beat strobe, no back-pressure |
| rx_data | output | 8 | Received byte |
| rx_index | output | $clog2(BUF_BYTES) (4) | Byte position within the packet |
| pkt_done | output | 1 | One-cycle end-of-packet strobe |
| pkt_bytes | output | $clog2(BUF_BYTES+1) (4) | Bytes delivered, valid with `pkt_done` |
| pkt_overflow | output | 1 | Buffer limit exceeded, valid with `pkt_done` |

## Verification
A stale reference line state or a miscounted ones-run inserts or removes a bit. Every later byte of the packet then shifts, so the error reaches `rx_data` within one byte time, about 107 cycles. Timing drift from a wrong period pattern accumulates more slowly. It shows up as corrupted bytes late in long, stuff-heavy packets, which the random packets exercise. A wrong byte counter or overflow flag shows only at `pkt_done`, in `pkt_bytes`, `pkt_overflow` or a wrong `rx_index`.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
  // line encoding {D+, D-}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_EDGE,
    ST_CONF,
    ST_DATA
  } rx_state_t;
endpackage

// File: rtl/usbrx_sync.sv
module usbrx_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/usbrx_timer.sv
module usbrx_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          tick
);
  logic [CW-1:0] cnt;

  // a load of N makes the next tick act N edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign tick = (cnt == CW'(1));
endmodule

// File: rtl/usbrx_assemble.sv
module usbrx_assemble #(
  parameter int LEAP_DIV = 3,
  localparam int PW = (LEAP_DIV > 1) ? $clog2(LEAP_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bit_stb,
  input  logic          bit_val,
  output logic          byte_stb,
  output logic [7:0]    byte_data,
  output logic [2:0]    bit_idx,
  output logic [PW-1:0] byte_ph
);
  logic [7:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_idx <= '0;
      byte_ph <= '0;
    end else if (clr) begin
      sh      <= '0;
      bit_idx <= '0;
      byte_ph <= '0;
    end else if (bit_stb) begin
      sh <= {bit_val, sh[7:1]};
      if (bit_idx == 3'd7) begin
        bit_idx <= '0;
        byte_ph <= (int'(byte_ph) == LEAP_DIV - 1) ? '0 : byte_ph + PW'(1);
      end else begin
        bit_idx <= bit_idx + 3'd1;
      end
    end
  end

  assign byte_stb  = bit_stb && (bit_idx == 3'd7);
  assign byte_data = {bit_val, sh[7:1]};
endmodule

// File: rtl/usbrx_bufctl.sv
module usbrx_bufctl #(
  parameter int BUF_BYTES = 12,
  localparam int IW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
  localparam int LW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          byte_stb,
  input  logic [7:0]    byte_data,
  input  logic          eop,
  output logic          wr_valid,
  output logic [7:0]    wr_data,
  output logic [IW-1:0] wr_idx,
  output logic          done,
  output logic [LW-1:0] done_len,
  output logic          done_ovf
);
  logic [LW-1:0] cnt;
  logic          ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      ovf      <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_idx   <= '0;
      done     <= 1'b0;
      done_len <= '0;
      done_ovf <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      done     <= 1'b0;
      if (clr) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else if (byte_stb) begin
        if (cnt == LW'(BUF_BYTES)) begin
          ovf <= 1'b1;
        end else begin
          wr_valid <= 1'b1;
          wr_data  <= byte_data;
          wr_idx   <= cnt[IW-1:0];
          cnt      <= cnt + LW'(1);
        end
      end else if (eop) begin
        done     <= 1'b1;
        done_len <= cnt;
        done_ovf <= ovf;
      end
    end
  end
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usbrx_pkg::*;
#(
  parameter int          BASE_CYC  = 13,
  parameter int          HALF_CYC  = 5,
  parameter logic [7:0]  LONG_MASK = 8'b1001_0010,
  parameter int          SKIP_IDX  = 7,
  parameter int          LEAP_DIV  = 3,
  parameter int          STUFF_DIV = 3,
  parameter int          RUN_MAX   = 6,
  parameter int          BUF_BYTES = 12,
  localparam int IW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
  localparam int LW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usb_dp,
  input  logic          usb_dm,
  output logic          rx_valid,
  output logic [7:0]    rx_data,
  output logic [IW-1:0] rx_index,
  output logic          pkt_done,
  output logic [LW-1:0] pkt_bytes,
  output logic          pkt_overflow
);
  localparam int TW = $clog2(BASE_CYC + 2);
  localparam int RW = $clog2(RUN_MAX + 1);
  localparam int PW = (LEAP_DIV > 1) ? $clog2(LEAP_DIV) : 1;
  localparam int SW = (STUFF_DIV > 1) ? $clog2(STUFF_DIV) : 1;

  logic [1:0]    ln_raw;
  line_t         ln, ln_q, prev_ln;
  rx_state_t     st, st_nx;
  logic [RW-1:0] run, run_nx;
  logic [SW-1:0] stf_ph;
  logic          tick, ld, bit_stb, clr, eop;
  logic [TW-1:0] ld_val;
  logic [2:0]    bit_idx, idx_after;
  logic [PW-1:0] byte_ph, ph_after;
  logic          byte_stb, one_bit, stuff_now;
  logic [7:0]    byte_data;

  // length of a data bit at index i in a byte of leap phase p
  function automatic logic [TW-1:0] data_len(input logic [2:0] i, input logic [PW-1:0] p);
    logic add;
    add = LONG_MASK[i] && !((int'(i) == SKIP_IDX) && (int'(p) == LEAP_DIV - 1));
    return TW'(BASE_CYC) + TW'(add);
  endfunction

  function automatic logic [TW-1:0] stuff_len(input logic [SW-1:0] p);
    return TW'(BASE_CYC) + TW'(int'(p) == STUFF_DIV - 1);
  endfunction

  usbrx_sync #(.W(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({usb_dp, usb_dm}), .q(ln_raw)
  );
  assign ln = line_t'(ln_raw);

  usbrx_timer #(.CW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .tick(tick)
  );

  usbrx_assemble #(.LEAP_DIV(LEAP_DIV)) u_asm (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_stb(bit_stb), .bit_val(one_bit),
    .byte_stb(byte_stb), .byte_data(byte_data), .bit_idx(bit_idx), .byte_ph(byte_ph)
  );

  usbrx_bufctl #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .byte_stb(byte_stb), .byte_data(byte_data),
    .eop(eop), .wr_valid(rx_valid), .wr_data(rx_data), .wr_idx(rx_index),
    .done(pkt_done), .done_len(pkt_bytes), .done_ovf(pkt_overflow)
  );

  // NRZI: unchanged line is a one
  assign one_bit   = (ln == prev_ln);
  assign stuff_now = (int'(run) == RUN_MAX);
  assign run_nx    = one_bit ? run + RW'(1) : '0;
  assign idx_after = (bit_idx == 3'd7) ? 3'd0 : bit_idx + 3'd1;
  assign ph_after  = (bit_idx != 3'd7) ? byte_ph :
                     (int'(byte_ph) == LEAP_DIV - 1) ? '0 : byte_ph + PW'(1);

  always_comb begin
    st_nx   = st;
    ld      = 1'b0;
    ld_val  = TW'(BASE_CYC);
    bit_stb = 1'b0;
    clr     = 1'b0;
    eop     = 1'b0;
    case (st)
      ST_HUNT: begin
        if (ln_q == LN_J && ln == LN_K) begin
          ld     = 1'b1;
          ld_val = TW'(HALF_CYC);
          st_nx  = ST_EDGE;
        end
      end
      ST_EDGE: begin
        if (tick) begin
          if (ln == LN_K) begin
            ld     = 1'b1;
            ld_val = TW'(BASE_CYC);
            st_nx  = ST_CONF;
          end else begin
            st_nx = ST_HUNT;
          end
        end
      end
      ST_CONF: begin
        if (tick) begin
          if (ln == LN_K) begin
            ld     = 1'b1;
            ld_val = data_len(3'd0, '0);
            clr    = 1'b1;
            st_nx  = ST_DATA;
          end else begin
            st_nx = ST_HUNT;
          end
        end
      end
      default: begin
        if (tick) begin
          if (ln == LN_SE0) begin
            eop   = 1'b1;
            st_nx = ST_HUNT;
          end else if (stuff_now) begin
            ld     = 1'b1;
            ld_val = data_len(bit_idx, byte_ph);
          end else begin
            bit_stb = 1'b1;
            ld      = 1'b1;
            ld_val  = (int'(run_nx) == RUN_MAX) ? stuff_len(stf_ph)
                                                 : data_len(idx_after, ph_after);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_HUNT;
      ln_q    <= LN_J;
      prev_ln <= LN_K;
      run     <= '0;
      stf_ph  <= '0;
    end else begin
      st   <= st_nx;
      ln_q <= ln;
      if (clr) begin
        prev_ln <= LN_K;
        run     <= '0;
        stf_ph  <= '0;
      end else if (st == ST_DATA && tick && ln != LN_SE0) begin
        prev_ln <= ln;
        if (stuff_now) begin
          run    <= '0;
          stf_ph <= (int'(stf_ph) == STUFF_DIV - 1) ? '0 : stf_ph + SW'(1);
        end else begin
          run <= run_nx;
        end
      end
    end
  end
endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk #(
  parameter int BUF_BYTES = 12,
  localparam int IW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
  localparam int LW = $clog2(BUF_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic [IW-1:0] rx_index,
  input logic          pkt_done,
  input logic [LW-1:0] pkt_bytes
);
  logic [7:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen <= '0;
    else if (pkt_done) seen <= '0;
    else if (rx_valid) seen <= seen + 8'd1;
  end

  p_valid_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_index_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> 8'(rx_index) == seen);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);
  p_done_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> 8'(pkt_bytes) == seen);
  p_no_mix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !pkt_done);
  p_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> int'(rx_index) < BUF_BYTES);
endmodule

bind usb_ls_rx usb_ls_rx_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_index(rx_index),
  .pkt_done(pkt_done), .pkt_bytes(pkt_bytes)
);

// File: tb/sim_usb_ls_rx.sv
module sim_usb_ls_rx;
  localparam int BUF = 12;
  localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LSE0 = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0, usb_dp = 1'b0, usb_dm = 1'b1;
  logic rx_valid, pkt_done, pkt_overflow;
  logic [7:0] rx_data;
  logic [3:0] rx_index, pkt_bytes;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  usb_ls_rx #(.BUF_BYTES(BUF)) u0 (
    .clk(clk), .rst_n(rst_n), .usb_dp(usb_dp), .usb_dm(usb_dm),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_index(rx_index),
    .pkt_done(pkt_done), .pkt_bytes(pkt_bytes), .pkt_overflow(pkt_overflow)
  );

  // monitor
  logic [7:0] gd [0:4095];
  int         gi [0:4095];
  int gn = 0, dn = 0, dlen = 0, dovf = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        if (gn < 4096) begin gd[gn] = rx_data; gi[gn] = int'(rx_index); end
        gn++;
      end
      if (pkt_done) begin
        dn++; dlen = int'(pkt_bytes); dovf = int'(pkt_overflow);
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int exp_count(input int n);
    return (n > BUF) ? BUF : n;
  endfunction

  function automatic int exp_ovf(input int n);
    return (n > BUF) ? 1 : 0;
  endfunction

  logic [7:0] pkt [0:31];
  logic [1:0] lv [0:1023];
  int nl;

  task automatic put(input logic [1:0] v);
    lv[nl] = v; nl++;
  endtask

  // line states of one packet: sync, NRZI data with stuffing, EOP
  task automatic build(input int n, input int extra);
    logic [1:0] cur;
    int run;
    nl = 0;
    put(LK); put(LJ); put(LK); put(LJ); put(LK); put(LJ); put(LK); put(LK);
    cur = LK; run = 0;
    for (int b = 0; b < n * 8 + extra; b++) begin
      bit v;
      if (b < n * 8) v = pkt[b / 8][b % 8];
      else v = 1'($urandom_range(0, 1));
      if (v) run++;
      else begin cur = ~cur; run = 0; end
      put(cur);
      if (run == 6) begin cur = ~cur; put(cur); run = 0; end
    end
    put(LSE0); put(LSE0); put(LJ);
  endtask

  task automatic drive(input logic [1:0] v, input int cyc);
    usb_dp = v[1]; usb_dm = v[0];
    repeat (cyc) @(negedge clk);
  endtask

  // exactly 40/3 cycles per bit
  task automatic emit();
    for (int k = 0; k < nl; k++)
      drive(lv[k], ((k + 1) * 40) / 3 - (k * 40) / 3);
  endtask

  task automatic run_pkt(input int n, input int extra, input string tag);
    int gb, db, e;
    gb = gn; db = dn;
    drive(LJ, $urandom_range(5, 30));
    build(n, extra);
    emit();
    drive(LJ, 40);
    e = exp_count(n);
    chk(gn - gb == e, $sformatf("%s beat count", tag), gn - gb, e);
    for (int i = 0; i < e && i < gn - gb; i++) begin
      chk(gd[gb + i] == pkt[i], $sformatf("%s byte %0d", tag, i), int'(gd[gb + i]), int'(pkt[i]));
      chk(gi[gb + i] == i, $sformatf("R3 index of byte %0d", i), gi[gb + i], i);
    end
    chk(dn - db == 1, "R6 one done strobe", dn - db, 1);
    chk(dlen == e, "R6 done byte count", dlen, e);
    chk(dovf == exp_ovf(n), "R7 overflow flag", dovf, exp_ovf(n));
  endtask

  task automatic no_activity(input string what, input int gb, input int db);
    chk(gn == gb, {what, " no beat"}, gn - gb, 0);
    chk(dn == db, {what, " no done"}, dn - db, 0);
  endtask

  initial begin
    int gb, db;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk(rx_valid == 0 && pkt_done == 0, "R1 strobes in reset", int'(rx_valid) + int'(pkt_done), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pkt_bytes == 0 && pkt_overflow == 0, "R1 status after reset",
        int'(pkt_bytes) + int'(pkt_overflow), 0);

    // R2: lone K bit, short K spike, broken sync
    gb = gn; db = dn;
    drive(LJ, 20); drive(LK, 13); drive(LJ, 80);
    no_activity("R2 lone K bit", gb, db);
    drive(LK, 3); drive(LJ, 80);
    no_activity("R2 K spike", gb, db);
    drive(LK, 13); drive(LJ, 14); drive(LK, 13); drive(LJ, 14); drive(LJ, 80);
    no_activity("R2 partial sync", gb, db);

    // R3: zeros and a mixed pattern
    for (int i = 0; i < 4; i++) pkt[i] = 8'h00;
    run_pkt(4, 0, "R3 zeros");
    pkt[0] = 8'hA5; pkt[1] = 8'h3C; pkt[2] = 8'h01; pkt[3] = 8'h80;
    run_pkt(4, 0, "R3 mixed");

    // R4: all ones, heavy stuffing incl. at the end
    for (int i = 0; i < 6; i++) pkt[i] = 8'hFF;
    run_pkt(6, 0, "R4 stuffing");
    pkt[0] = 8'h7E; pkt[1] = 8'hFC; pkt[2] = 8'h3F;
    run_pkt(3, 0, "R4 stuff boundary");

    // R6: trailing partial byte is dropped
    pkt[0] = 8'h12; pkt[1] = 8'h34; pkt[2] = 8'h56;
    run_pkt(3, 5, "R6 partial byte");

    // R7: exactly at the limit, then beyond it
    for (int i = 0; i < BUF; i++) pkt[i] = 8'(i * 17 + 3);
    run_pkt(BUF, 0, "R7 at limit");
    for (int i = 0; i < BUF + 2; i++) pkt[i] = 8'hFF;
    run_pkt(BUF + 2, 0, "R7 over limit");

    // R8: normal packet after overflow
    pkt[0] = 8'hC3; pkt[1] = 8'h5A;
    run_pkt(2, 0, "R8 after overflow");

    // R5: random long packets at the exact fractional rate
    for (int t = 0; t < 20; t++) begin
      int n, ex;
      n = $urandom_range(1, BUF + 2);
      for (int i = 0; i < n; i++)
        pkt[i] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
      ex = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, 7);
      run_pkt(n, ex, "R5 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule